// File: doc/BRIEF.md
# Asymmetric Link Aggregation Subrouter

This block sits between a set of narrow, slow serial-link ports and one wide port of an on-board packet router. It exists to hide the bandwidth mismatch between the two sides: every path through it is buffered, so a slow link never stalls the router directly. Frames are sequences of words, and a separate flag marks the final word of each frame.

In the receive direction, each serial input port has its own buffer. A round-robin arbiter picks one port with a waiting frame. Only the last-served port drops to lowest priority. The chosen port then owns the merge until the final word of its frame has passed, so frames from different links never mix in the shared aggregate buffer that feeds the router. In the transmit direction, frames from the router land in a buffer. The first word of each frame names the outgoing serial port, and the whole frame is steered into that port's outbound buffer. This direction has no arbitration stage, so it is one cycle faster than the receive direction. Every full buffer stops its producer through a ready signal, and no word is ever dropped.

The number of serial ports (a power of two, at least 2), the word width and both buffer depths are parameters. The defaults are 8 ports, 16-bit words, 4-word per-port buffers and 8-word aggregate buffers.

Top module: `lagg_subrouter`

## Requirements
- R1: While reset is asserted, and right after it, `rtr_out_valid` and every `ser_tx_valid` bit are 0, and `rtr_in_ready` and every `ser_rx_ready` bit are 1. Any buffered words are discarded.
- R2: On the receive side, a frame from one port leaves on the router side as one contiguous run of words, in order, with `rtr_out_last` set only on its final word. Words of a frame from another port never appear between them.
- R3: When several receive ports hold waiting frames at the moment of a decision, the port chosen is the first one with a waiting frame, searching upward (with wrap-around) from the port granted last. After reset, the search starts at port 0.
- R4: A single-word frame accepted on an idle receive port at clock edge k is not yet visible after edge k+1, and `rtr_out_valid` is 1 after edge k+2.
- R5: On the transmit side, bits [log2(N_PORTS)-1:0] of the first word of a frame select the outgoing port. Every word of the frame, including that first word, appears in order on that port only, with `ser_tx_last` set only on the final word.
- R6: A single-word frame accepted on `rtr_in` at edge k, with its target port empty, makes that port's `ser_tx_valid` 1 after edge k+1, and not yet after edge k.
- R7: When a transmit port's outbound buffer is full and its `ser_tx_ready` is low, `rtr_in_ready` drops after PORT_DEPTH+AGG_DEPTH words of that frame have been accepted. A held word stays stable, and after the port is released every word arrives in order.
- R8: When the router side does not take words, a receive port accepts exactly PORT_DEPTH+AGG_DEPTH words of a frame before its `ser_rx_ready` drops. No accepted word is lost.
- R9: While `rtr_out_valid` is 1 and `rtr_out_ready` is 0, the offered word and flag stay unchanged, and the word is delivered once the router takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_rx_valid | input | N_PORTS | Word offered per serial receive port |
| ser_rx_data | input | N_PORTS*DATA_W | Word per serial receive port, port i at bits [i*DATA_W +: DATA_W] |
| ser_rx_last | input | N_PORTS | Final-word flag per serial receive port |
| ser_rx_ready | output | N_PORTS | Receive port buffer has room |
| rtr_out_valid | output | 1 | Merged word offered to the router |
| rtr_out_data | output | DATA_W | Merged word |
| rtr_out_last | output | 1 | Final word of the merged frame |
| rtr_out_ready | input | 1 | Router takes the merged word |
| rtr_in_valid | input | 1 | Router offers a word to send out |
| rtr_in_data | input | DATA_W | Word from the router; the first word of a frame carries the port number in its low bits |
| rtr_in_last | input | 1 | Final word of the router frame |
| rtr_in_ready | output | 1 | Transmit input buffer has room |
| ser_tx_valid | output | N_PORTS | Word offered per serial transmit port |
| ser_tx_data | output | N_PORTS*DATA_W | Word per serial transmit port |
| ser_tx_last | output | N_PORTS | Final-word flag per serial transmit port |
| ser_tx_ready | input | N_PORTS | Serial link takes the word |

## Verification
The hardest situation to reach is full back-pressure in each direction. A frame has to fill both the per-port buffer and the aggregate buffer behind it, so the stimulus holds the far side's ready low and pushes one long frame until the near-side ready drops. The bench then counts the accepted words exactly and releases the far side to confirm that nothing was lost. Round-robin rotation is shown by loading several ports in the same cycle, in a sequence chosen so that a higher-numbered port is served before a lower one.

// File: rtl/lagg_pkg.sv
package lagg_pkg;
  // Per-direction frame ownership: idle between frames, busy inside one.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } path_state_e;
endpackage

// File: rtl/lagg_fifo.sv
module lagg_fifo #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/lagg_rr_arb.sv
module lagg_rr_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    int cand;
    gnt_any = 1'b0;
    gnt_idx = '0;
    cand    = 0;
    for (int off = 1; off <= N; off++) begin
      cand = (int'(last_q) + off) % N;
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (advance && gnt_any) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/lagg_rx_merge.sv
module lagg_rx_merge
  import lagg_pkg::*;
#(
  parameter int N          = 8,
  parameter int W          = 16,
  parameter int PORT_DEPTH = 4,
  parameter int AGG_DEPTH  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N*W-1:0]  in_data,
  input  logic [N-1:0]    in_last,
  output logic [N-1:0]    in_ready,
  output logic            out_valid,
  output logic [W-1:0]    out_data,
  output logic            out_last,
  input  logic            out_ready,
  output logic            busy,
  output logic [IW-1:0]   owner,
  output logic            start,
  output logic [IW-1:0]   grant,
  output logic [N-1:0]    pending,
  output logic            move,
  output logic            move_last
);
  path_state_e   st_q, st_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [W:0]    head [N];
  logic [N-1:0]  port_full, port_empty;
  logic [W:0]    head_sel;
  logic          gnt_any, agg_full, agg_empty;
  logic [W:0]    agg_rdata;

  for (genvar i = 0; i < N; i++) begin : g_port
    lagg_fifo #(.WIDTH(W + 1), .DEPTH(PORT_DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i]),
      .wdata ({in_last[i], in_data[i*W +: W]}),
      .pop   (move && (owner_q == IW'(i))),
      .rdata (head[i]),
      .full  (port_full[i]),
      .empty (port_empty[i])
    );
  end

  assign in_ready = ~port_full;
  assign pending  = ~port_empty;

  lagg_rr_arb #(.N(N)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pending),
    .advance (start),
    .gnt_idx (grant),
    .gnt_any (gnt_any)
  );

  assign start     = (st_q == ST_IDLE) && gnt_any;
  assign head_sel  = head[owner_q];
  assign move      = (st_q == ST_BUSY) && pending[owner_q] && !agg_full;
  assign move_last = head_sel[W];

  always_comb begin
    st_d    = st_q;
    owner_d = owner_q;
    if (start) begin
      st_d    = ST_BUSY;
      owner_d = grant;
    end else if (move && move_last) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      owner_q <= '0;
    end else begin
      st_q    <= st_d;
      owner_q <= owner_d;
    end
  end

  lagg_fifo #(.WIDTH(W + 1), .DEPTH(AGG_DEPTH)) u_agg (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (move),
    .wdata (head_sel),
    .pop   (out_ready),
    .rdata (agg_rdata),
    .full  (agg_full),
    .empty (agg_empty)
  );

  assign out_valid = !agg_empty;
  assign out_data  = agg_rdata[W-1:0];
  assign out_last  = agg_rdata[W];
  assign busy      = (st_q == ST_BUSY);
  assign owner     = owner_q;
endmodule

// File: rtl/lagg_tx_steer.sv
module lagg_tx_steer
  import lagg_pkg::*;
#(
  parameter int N          = 8,
  parameter int W          = 16,
  parameter int PORT_DEPTH = 4,
  parameter int AGG_DEPTH  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  input  logic           in_last,
  output logic           in_ready,
  output logic [N-1:0]   tx_valid,
  output logic [N*W-1:0] tx_data,
  output logic [N-1:0]   tx_last,
  input  logic [N-1:0]   tx_ready
);
  path_state_e   st_q, st_d;
  logic [IW-1:0] dest_q, dest_d, target, hdr_dest;
  logic [W:0]    head;
  logic          in_full, in_empty, fwd;
  logic [N-1:0]  port_full, port_empty;
  logic [W:0]    port_rdata [N];

  lagg_fifo #(.WIDTH(W + 1), .DEPTH(AGG_DEPTH)) u_in (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .wdata ({in_last, in_data}),
    .pop   (fwd),
    .rdata (head),
    .full  (in_full),
    .empty (in_empty)
  );

  assign in_ready = !in_full;
  assign hdr_dest = head[IW-1:0];
  assign target   = (st_q == ST_IDLE) ? hdr_dest : dest_q;
  assign fwd      = !in_empty && !port_full[target];

  always_comb begin
    st_d   = st_q;
    dest_d = dest_q;
    if (fwd) begin
      if (st_q == ST_IDLE) begin
        dest_d = hdr_dest;
        if (!head[W]) st_d = ST_BUSY;
      end else if (head[W]) begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dest_q <= '0;
    end else begin
      st_q   <= st_d;
      dest_q <= dest_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    lagg_fifo #(.WIDTH(W + 1), .DEPTH(PORT_DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fwd && (target == IW'(i))),
      .wdata (head),
      .pop   (tx_ready[i]),
      .rdata (port_rdata[i]),
      .full  (port_full[i]),
      .empty (port_empty[i])
    );
    assign tx_valid[i]        = !port_empty[i];
    assign tx_data[i*W +: W]  = port_rdata[i][W-1:0];
    assign tx_last[i]         = port_rdata[i][W];
  end
endmodule

// File: rtl/lagg_subrouter.sv
module lagg_subrouter #(
  parameter int N_PORTS    = 8,
  parameter int DATA_W     = 16,
  parameter int PORT_DEPTH = 4,
  parameter int AGG_DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        ser_rx_valid,
  input  logic [N_PORTS*DATA_W-1:0] ser_rx_data,
  input  logic [N_PORTS-1:0]        ser_rx_last,
  output logic [N_PORTS-1:0]        ser_rx_ready,
  output logic                      rtr_out_valid,
  output logic [DATA_W-1:0]         rtr_out_data,
  output logic                      rtr_out_last,
  input  logic                      rtr_out_ready,
  input  logic                      rtr_in_valid,
  input  logic [DATA_W-1:0]         rtr_in_data,
  input  logic                      rtr_in_last,
  output logic                      rtr_in_ready,
  output logic [N_PORTS-1:0]        ser_tx_valid,
  output logic [N_PORTS*DATA_W-1:0] ser_tx_data,
  output logic [N_PORTS-1:0]        ser_tx_last,
  input  logic [N_PORTS-1:0]        ser_tx_ready
);
  localparam int IW = $clog2(N_PORTS);

  logic               rx_busy, rx_start, rx_move, rx_move_last;
  logic [IW-1:0]      rx_owner, rx_grant;
  logic [N_PORTS-1:0] rx_pending;

  lagg_rx_merge #(
    .N(N_PORTS), .W(DATA_W), .PORT_DEPTH(PORT_DEPTH), .AGG_DEPTH(AGG_DEPTH)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ser_rx_valid),
    .in_data   (ser_rx_data),
    .in_last   (ser_rx_last),
    .in_ready  (ser_rx_ready),
    .out_valid (rtr_out_valid),
    .out_data  (rtr_out_data),
    .out_last  (rtr_out_last),
    .out_ready (rtr_out_ready),
    .busy      (rx_busy),
    .owner     (rx_owner),
    .start     (rx_start),
    .grant     (rx_grant),
    .pending   (rx_pending),
    .move      (rx_move),
    .move_last (rx_move_last)
  );

  lagg_tx_steer #(
    .N(N_PORTS), .W(DATA_W), .PORT_DEPTH(PORT_DEPTH), .AGG_DEPTH(AGG_DEPTH)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rtr_in_valid),
    .in_data  (rtr_in_data),
    .in_last  (rtr_in_last),
    .in_ready (rtr_in_ready),
    .tx_valid (ser_tx_valid),
    .tx_data  (ser_tx_data),
    .tx_last  (ser_tx_last),
    .tx_ready (ser_tx_ready)
  );
endmodule

// File: rtl/lagg_subrouter_chk.sv
module lagg_subrouter_chk #(
  parameter int N_PORTS    = 8,
  parameter int DATA_W     = 16,
  parameter int PORT_DEPTH = 4,
  parameter int AGG_DEPTH  = 8,
  localparam int IW = $clog2(N_PORTS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_PORTS-1:0]        ser_rx_valid,
  input logic [N_PORTS-1:0]        ser_rx_ready,
  input logic                      rtr_out_valid,
  input logic [DATA_W-1:0]         rtr_out_data,
  input logic                      rtr_out_last,
  input logic                      rtr_out_ready,
  input logic [N_PORTS-1:0]        ser_tx_valid,
  input logic [N_PORTS*DATA_W-1:0] ser_tx_data,
  input logic [N_PORTS-1:0]        ser_tx_last,
  input logic [N_PORTS-1:0]        ser_tx_ready,
  input logic                      rx_busy,
  input logic [IW-1:0]             rx_owner,
  input logic                      rx_start,
  input logic [IW-1:0]             rx_grant,
  input logic [N_PORTS-1:0]        rx_pending,
  input logic                      rx_move,
  input logic                      rx_move_last
);
  localparam int CAP = N_PORTS * PORT_DEPTH + AGG_DEPTH;

  int                 occ_q;
  logic [IW-1:0]      last_g_q;
  logic               seen_q;
  logic [N_PORTS-1:0] last_mask;

  assign last_mask = {{(N_PORTS-1){1'b0}}, 1'b1} << last_g_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q    <= 0;
      last_g_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      occ_q <= occ_q + $countones(ser_rx_valid & ser_rx_ready)
                     - ((rtr_out_valid && rtr_out_ready) ? 1 : 0);
      if (rx_start) begin
        last_g_q <= rx_grant;
        seen_q   <= 1'b1;
      end
    end
  end

  // R8: accepted receive words never exceed the buffering behind the ports
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q <= CAP));

  // R9: a held router-side word stays put
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rtr_out_valid && !rtr_out_ready) |=>
      (rtr_out_valid && $stable(rtr_out_data) && $stable(rtr_out_last)));

  // R2: the merge keeps its owner until the owner's final word moves
  p_owner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !(rx_move && rx_move_last)) |=>
      (rx_busy && (rx_owner == $past(rx_owner))));

  // R3: the last-served port loses to any other waiting port
  p_rr_fair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && seen_q && ((rx_pending & ~last_mask) != '0)) |->
      (rx_grant != last_g_q));

  for (genvar i = 0; i < N_PORTS; i++) begin : g_tx
    // R7: a held serial transmit word stays put
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_tx_valid[i] && !ser_tx_ready[i]) |=>
        (ser_tx_valid[i] && $stable(ser_tx_data[i*DATA_W +: DATA_W])
         && $stable(ser_tx_last[i])));
  end
endmodule

bind lagg_subrouter lagg_subrouter_chk #(
  .N_PORTS(N_PORTS), .DATA_W(DATA_W), .PORT_DEPTH(PORT_DEPTH), .AGG_DEPTH(AGG_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ser_rx_valid  (ser_rx_valid),
  .ser_rx_ready  (ser_rx_ready),
  .rtr_out_valid (rtr_out_valid),
  .rtr_out_data  (rtr_out_data),
  .rtr_out_last  (rtr_out_last),
  .rtr_out_ready (rtr_out_ready),
  .ser_tx_valid  (ser_tx_valid),
  .ser_tx_data   (ser_tx_data),
  .ser_tx_last   (ser_tx_last),
  .ser_tx_ready  (ser_tx_ready),
  .rx_busy       (rx_busy),
  .rx_owner      (rx_owner),
  .rx_start      (rx_start),
  .rx_grant      (rx_grant),
  .rx_pending    (rx_pending),
  .rx_move       (rx_move),
  .rx_move_last  (rx_move_last)
);

// File: tb/lagg_subrouter_test.sv
module lagg_subrouter_test;
  localparam int CLK_PERIOD = 4;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int PD = 4;
  localparam int AD = 8;

  // transmit vectors: {dest[2:0], length[2:0], seed[7:0]}
  localparam logic [13:0] TXV [6] = '{
    {3'd5, 3'd3, 8'hA1}, {3'd0, 3'd1, 8'hB2}, {3'd7, 3'd4, 8'hC3},
    {3'd2, 3'd2, 8'hD4}, {3'd7, 3'd1, 8'hE5}, {3'd3, 3'd6, 8'hF6}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   ser_rx_valid, ser_rx_last, ser_rx_ready;
  logic [N*W-1:0] ser_rx_data;
  logic           rtr_out_valid, rtr_out_last, rtr_out_ready;
  logic [W-1:0]   rtr_out_data;
  logic           rtr_in_valid, rtr_in_last, rtr_in_ready;
  logic [W-1:0]   rtr_in_data;
  logic [N-1:0]   ser_tx_valid, ser_tx_last, ser_tx_ready;
  logic [N*W-1:0] ser_tx_data;

  int nchecks = 0;
  int errors  = 0;
  int cyc     = 0;

  logic [16:0] rxlog [$];
  logic [20:0] txlog [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lagg_subrouter uut (
    .clk(clk), .rst_n(rst_n),
    .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data),
    .ser_rx_last(ser_rx_last), .ser_rx_ready(ser_rx_ready),
    .rtr_out_valid(rtr_out_valid), .rtr_out_data(rtr_out_data),
    .rtr_out_last(rtr_out_last), .rtr_out_ready(rtr_out_ready),
    .rtr_in_valid(rtr_in_valid), .rtr_in_data(rtr_in_data),
    .rtr_in_last(rtr_in_last), .rtr_in_ready(rtr_in_ready),
    .ser_tx_valid(ser_tx_valid), .ser_tx_data(ser_tx_data),
    .ser_tx_last(ser_tx_last), .ser_tx_ready(ser_tx_ready)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rtr_out_valid && rtr_out_ready) rxlog.push_back({rtr_out_last, rtr_out_data});
      for (int i = 0; i < N; i++)
        if (ser_tx_valid[i] && ser_tx_ready[i])
          txlog.push_back({4'(i), ser_tx_last[i], ser_tx_data[i*W +: W]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      nchecks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, nchecks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ser_rx_valid = '0;
    rtr_in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rxlog.delete();
    txlog.delete();
  endtask

  task automatic tx_push(input logic [W-1:0] d, input logic l, output bit ok);
    int t = 0;
    rtr_in_data = d; rtr_in_last = l; rtr_in_valid = 1'b1;
    while (!rtr_in_ready && t < 30) begin @(negedge clk); t++; end
    ok = rtr_in_ready;
    @(negedge clk);
    rtr_in_valid = 1'b0;
  endtask

  task automatic rx_push(input int p, input logic [W-1:0] d, input logic l, output bit ok);
    int t = 0;
    ser_rx_data[p*W +: W] = d; ser_rx_last[p] = l; ser_rx_valid[p] = 1'b1;
    while (!ser_rx_ready[p] && t < 30) begin @(negedge clk); t++; end
    ok = ser_rx_ready[p];
    @(negedge clk);
    ser_rx_valid[p] = 1'b0;
  endtask

  // all ports in mask send a len-word frame in lockstep; data {port, index, tag}
  task automatic rx_burst(input logic [N-1:0] mask, input int len, input logic [7:0] tag);
    for (int k = 0; k < len; k++) begin
      for (int p = 0; p < N; p++) begin
        ser_rx_data[p*W +: W] = {4'(p), 4'(k), tag};
        ser_rx_last[p] = (k == len - 1);
      end
      ser_rx_valid = mask;
      @(negedge clk);
    end
    ser_rx_valid = '0;
  endtask

  function automatic logic [31:0] rx_ports();
    logic [31:0] s = '0;
    foreach (rxlog[j]) s = (s << 4) | 32'(rxlog[j][15:12]);
    return s;
  endfunction

  function automatic logic [W-1:0] tx_word(input logic [2:0] d, input logic [7:0] seed, input int k);
    return (k == 0) ? {seed, 5'd0, d} : {seed, 8'(k)};
  endfunction

  initial begin
    bit ok;
    int acc;
    logic [31:0] s, sl;
    rst_n = 1'b0;
    ser_rx_valid = '0; ser_rx_data = '0; ser_rx_last = '0;
    rtr_out_ready = 1'b1;
    rtr_in_valid = 1'b0; rtr_in_data = '0; rtr_in_last = 1'b0;
    ser_tx_ready = '1;
    do_reset();

    // R1: idle state after reset
    chk("R1", "valids after reset", {31'(ser_tx_valid), rtr_out_valid}, 32'h0);
    chk("R1", "readies after reset", {31'(ser_rx_ready), rtr_in_ready}, {23'h0, 8'hFF, 1'b1});

    // R5: table of transmit frames walked by one loop
    for (int v = 0; v < 6; v++) begin
      logic [2:0] d; int len; logic [7:0] seed; bit bad;
      d = TXV[v][13:11]; len = int'(TXV[v][10:8]); seed = TXV[v][7:0];
      txlog.delete();
      for (int k = 0; k < len; k++) tx_push(tx_word(d, seed, k), k == len - 1, ok);
      repeat (6) @(negedge clk);
      chk("R5", "frame word count", txlog.size(), len);
      bad = 1'b0;
      foreach (txlog[j])
        if (txlog[j] !== {4'(d), (j == len - 1), tx_word(d, seed, j)}) bad = 1'b1;
      chk("R5", "frame port/data/last", 32'(bad), 32'h0);
    end

    // R6: transmit latency one edge
    rtr_in_data = tx_word(3'd6, 8'h77, 0); rtr_in_last = 1'b1; rtr_in_valid = 1'b1;
    @(negedge clk);
    rtr_in_valid = 1'b0;
    chk("R6", "tx valid after accept edge", 32'(ser_tx_valid[6]), 32'h0);
    @(negedge clk);
    chk("R6", "tx valid one edge later", 32'(ser_tx_valid[6]), 32'h1);
    repeat (3) @(negedge clk);

    // R4: receive latency two edges
    ser_rx_data[1*W +: W] = 16'h1234; ser_rx_last[1] = 1'b1; ser_rx_valid[1] = 1'b1;
    @(negedge clk);
    ser_rx_valid[1] = 1'b0;
    @(negedge clk);
    chk("R4", "rx valid one edge after accept", 32'(rtr_out_valid), 32'h0);
    @(negedge clk);
    chk("R4", "rx valid two edges after accept", 32'(rtr_out_valid), 32'h1);
    repeat (3) @(negedge clk);

    // R3: round-robin order from a fresh reset
    do_reset();
    rx_burst(8'b1010_0100, 1, 8'h31);
    repeat (12) @(negedge clk);
    chk("R3", "order ports 2,5,7", rx_ports(), 32'h257);
    rxlog.delete();
    rx_burst(8'b0100_1000, 1, 8'h32);
    repeat (12) @(negedge clk);
    chk("R3", "order ports 3,6", rx_ports(), 32'h36);
    rxlog.delete();
    rx_burst(8'b1100_0000, 1, 8'h33);
    repeat (12) @(negedge clk);
    chk("R3", "rotated order 7 before 6", rx_ports(), 32'h76);
    rxlog.delete();

    // R2: two simultaneous 3-word frames stay contiguous
    rx_burst(8'b0001_0001, 3, 8'h44);
    repeat (16) @(negedge clk);
    chk("R2", "port sequence", rx_ports(), 32'h000444);
    s = '0; sl = '0;
    foreach (rxlog[j]) begin
      s  = (s << 4) | 32'(rxlog[j][11:8]);
      sl = (sl << 1) | 32'(rxlog[j][16]);
    end
    chk("R2", "word index sequence", s, 32'h012012);
    chk("R2", "last flags", sl, 32'b001001);

    // R8/R9: router side stalled, one long frame on port 2
    do_reset();
    rtr_out_ready = 1'b0;
    acc = 0;
    for (int k = 0; k < 16; k++) begin
      rx_push(2, 16'h2000 + 16'(k), k == 15, ok);
      if (!ok) break;
      acc++;
    end
    chk("R8", "words accepted before stall", acc, PD + AD);
    chk("R8", "port ready low when full", 32'(ser_rx_ready[2]), 32'h0);
    chk("R9", "held word", {15'h0, rtr_out_valid, rtr_out_data}, {15'h0, 1'b1, 16'h2000});
    rtr_out_ready = 1'b1;
    for (int k = acc; k < 16; k++) rx_push(2, 16'h2000 + 16'(k), k == 15, ok);
    repeat (30) @(negedge clk);
    chk("R8", "all words delivered", rxlog.size(), 16);
    begin
      bit bad = 1'b0;
      foreach (rxlog[j]) if (rxlog[j] !== {(j == 15), 16'h2000 + 16'(j)}) bad = 1'b1;
      chk("R9", "delivered order and last", 32'(bad), 32'h0);
    end

    // R7: serial transmit port 3 stalled, one long frame
    do_reset();
    ser_tx_ready[3] = 1'b0;
    acc = 0;
    for (int k = 0; k < 16; k++) begin
      tx_push(tx_word(3'd3, 8'h5A, k), k == 15, ok);
      if (!ok) break;
      acc++;
    end
    chk("R7", "words accepted before stall", acc, PD + AD);
    chk("R7", "router ready low", 32'(rtr_in_ready), 32'h0);
    chk("R5", "no other port offered", 32'(ser_tx_valid), 32'h08);
    ser_tx_ready[3] = 1'b1;
    for (int k = acc; k < 16; k++) tx_push(tx_word(3'd3, 8'h5A, k), k == 15, ok);
    repeat (30) @(negedge clk);
    chk("R7", "all words delivered", txlog.size(), 16);
    begin
      bit bad = 1'b0;
      foreach (txlog[j])
        if (txlog[j] !== {4'd3, (j == 15), tx_word(3'd3, 8'h5A, j)}) bad = 1'b1;
      chk("R7", "delivered order and last", 32'(bad), 32'h0);
    end

    // R1: reset with words held on both sides
    rtr_out_ready = 1'b0;
    ser_tx_ready = '0;
    rx_burst(8'b0000_0001, 2, 8'h66);
    tx_push(tx_word(3'd1, 8'h67, 0), 1'b1, ok);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "valids cleared in reset", {31'(ser_tx_valid), rtr_out_valid}, 32'h0);
    chk("R1", "readies high in reset", {31'(ser_rx_ready), rtr_in_ready}, {23'h0, 8'hFF, 1'b1});
    rtr_out_ready = 1'b1;
    ser_tx_ready = '1;
    do_reset();
    repeat (4) @(negedge clk);
    chk("R1", "nothing emerges after reset", rxlog.size() + txlog.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end
endmodule